// File: doc/BRIEF.md
# Memory-display serial line writer

This block drives the three-wire write-only serial port of a 96×96 memory display with one bit per pixel. A host raises a one-cycle request with a command, a polarity bit, a first line number and a line count. The block then sends one complete frame and raises nothing else. A write frame carries one or more full lines, and their pixels are read from an external line buffer. A hold frame keeps the panel in its low-power retain mode while refreshing the common-electrode polarity. A clear frame blanks every pixel to white.

All pin timing is set in nanoseconds through parameters and converted into system-clock cycles: chip-select setup, hold and gap, and the half period of the serial clock. Serial data changes on the falling edge of the serial clock, and the panel samples it on the rising edge. The clock stays low whenever chip-select is low. The block reads each line's pixels from the buffer while that line's address record is being sent.

Top module: `mdisp_line_writer`

## Requirements
- R1: After reset, and whenever no frame is in progress, chip-select, serial clock, serial data, busy and the buffer read strobe are all low.
- R2: Every frame opens with three header bits in the order M0, M1, M2. The command input `cmd_i` uses these codes: 0 is write (M0=1, M2=0), 1 is hold (M0=0, M2=0), 2 is clear (M0=0, M2=1), and 3 is sent as hold. M1 copies `vcom_i` as it was at acceptance.
- R3: In a write frame the header is followed by 5 low dummy bits. Each line then sends its line number as 7 bits with the least significant bit first (line n is encoded as the value n), then one low dummy bit, then 96 pixel bits. The pixel bits go out in the order `lb_rd_data_i[0]` to `[95]` and keep their values (1 white, 0 black). Serial data is low whenever chip-select is low.
- R4: Successive lines of a write frame carry line numbers one higher than the previous line, and line 96 is followed by line 1. Lines are separated by 8 low dummy bits, and the last line is followed by 16 low dummy bits. A count of 0 writes one line.
- R5: Hold and clear frames send the header followed by exactly 13 low dummy bits.
- R6: The serial clock is high for HALF cycles and low for HALF cycles. Serial data changes only in the cycle the clock falls, so it is stable through every high phase.
- R7: Chip-select rises in the cycle after a request is accepted. The first rising clock edge comes SETUP cycles after that. Chip-select falls HOLD cycles after the last falling clock edge, and busy stays high for GAP cycles after chip-select falls.
- R8: A request is taken only while busy is low. A request raised while busy is high has no effect on the frame in progress and does not start a later frame.
- R9: For each line, `lb_rd_en_o` pulses for one cycle with `lb_rd_line_o` set to that line's number. The pulse comes in the first cycle that the line's first address bit is on the data pin. The buffer must present the line on `lb_rd_data_i` in the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Frame request, taken when busy is low |
| cmd_i | input | 2 | Command code (see R2) |
| vcom_i | input | 1 | Polarity bit sent as M1 |
| line_i | input | ADDR_W | First line number, 1 to 96 |
| count_i | input | ADDR_W | Number of lines to write |
| busy_o | output | 1 | Frame in progress |
| lb_rd_en_o | output | 1 | Line-buffer read strobe |
| lb_rd_line_o | output | ADDR_W | Line number being read |
| lb_rd_data_i | input | PIX_W | Line pixels, one cycle after the strobe |
| disp_cs_o | output | 1 | Panel chip-select, active high |
| disp_sclk_o | output | 1 | Panel serial clock |
| disp_sdo_o | output | 1 | Panel serial data |

## Verification
The bench aims at the record boundaries. It checks the wrap from line 96 to line 1: a design that skipped it would send address 97 or 0. It checks the 8-bit separator against the 16-bit tail, where an off-by-one would shift every later pixel by one clock. It checks the 5 versus 13 dummy bits after the header, which a design could easily swap between write and control frames. It also drives a request while busy is high: a design that took it would restart mid-frame or append a second frame. Every cycle of chip-select, clock, data and read strobe is compared against an independent model, so a data change in the wrong phase or a read strobe that comes early or late shows up at once.

// File: rtl/mdisp_pkg.sv
package mdisp_pkg;

  localparam logic [1:0] CMD_WRITE  = 2'd0;
  localparam logic [1:0] CMD_STATIC = 2'd1;
  localparam logic [1:0] CMD_CLEAR  = 2'd2;

  // serial frame layout, counted in serial clocks
  localparam int HDR_BITS = 3;
  localparam int LINE_PAD = 5;
  localparam int CTRL_PAD = 13;
  localparam int SEP_PAD  = 8;
  localparam int TAIL_PAD = 16;

  typedef enum logic [2:0] {
    SEG_HDR, SEG_PAD, SEG_ADR, SEG_ADM, SEG_PIX, SEG_SEP, SEG_TAIL
  } seg_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_HIGH, PH_LOW, PH_HOLD, PH_GAP
  } phase_t;

  function automatic int cyc_of(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/mdisp_phase_timer.sv
module mdisp_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/mdisp_line_fetch.sv
module mdisp_line_fetch #(
  parameter int PIX_W  = 96,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] line_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_line_o,
  input  logic [PIX_W-1:0]  rd_data_i,
  output logic [PIX_W-1:0]  pix_o
);
  logic vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en_o   <= 1'b0;
      rd_line_o <= '0;
      vld_q     <= 1'b0;
      pix_o     <= '0;
    end else begin
      rd_en_o <= req_i;
      if (req_i) rd_line_o <= line_i;
      vld_q <= rd_en_o;
      if (vld_q) pix_o <= rd_data_i;
    end
  end

  // one strobe per line, never two in a row
  assert_rd_single_R9: assert property (@(posedge clk) disable iff (rst)
    rd_en_o |=> !rd_en_o);
endmodule

// File: rtl/mdisp_bit_seq.sv
module mdisp_bit_seq
  import mdisp_pkg::*;
#(
  parameter int PIX_W  = 96,
  parameter int ADDR_W = 7,
  parameter int LINES  = 96
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              adv_i,
  input  logic [1:0]        cmd_i,
  input  logic              vcom_i,
  input  logic [ADDR_W-1:0] line_i,
  input  logic [ADDR_W-1:0] count_i,
  input  logic [PIX_W-1:0]  pix_i,
  output logic              sdo_o,
  output logic              last_o,
  output logic              fetch_o,
  output logic [ADDR_W-1:0] fetch_line_o
);
  localparam int IDX_W = $clog2((PIX_W > TAIL_PAD) ? PIX_W : TAIL_PAD);
  localparam int AI_W  = $clog2(ADDR_W);

  seg_t              seg, n_seg;
  logic [IDX_W-1:0]  idx, n_idx, len_m1;
  logic [ADDR_W-1:0] line, n_line, left, n_left;
  logic              wr, m1, clr, n_bit;

  always_comb begin
    case (seg)
      SEG_HDR: len_m1 = IDX_W'(HDR_BITS - 1);
      SEG_PAD: len_m1 = wr ? IDX_W'(LINE_PAD - 1) : IDX_W'(CTRL_PAD - 1);
      SEG_ADR: len_m1 = IDX_W'(ADDR_W - 1);
      SEG_ADM: len_m1 = '0;
      SEG_PIX: len_m1 = IDX_W'(PIX_W - 1);
      SEG_SEP: len_m1 = IDX_W'(SEP_PAD - 1);
      default: len_m1 = IDX_W'(TAIL_PAD - 1);
    endcase
  end

  always_comb begin
    n_seg  = seg;
    n_idx  = idx + 1'b1;
    n_line = line;
    n_left = left;
    last_o = 1'b0;
    if (idx == len_m1) begin
      n_idx = '0;
      case (seg)
        SEG_HDR: n_seg = SEG_PAD;
        SEG_PAD: if (wr) n_seg = SEG_ADR; else last_o = 1'b1;
        SEG_ADR: n_seg = SEG_ADM;
        SEG_ADM: n_seg = SEG_PIX;
        SEG_PIX: n_seg = (left > ADDR_W'(1)) ? SEG_SEP : SEG_TAIL;
        SEG_SEP: begin
          n_seg  = SEG_ADR;
          n_line = (line == ADDR_W'(LINES)) ? ADDR_W'(1) : line + 1'b1;
          n_left = left - 1'b1;
        end
        default: last_o = 1'b1;
      endcase
    end
    case (n_seg)
      SEG_HDR: n_bit = (n_idx == '0) ? wr : ((n_idx == IDX_W'(1)) ? m1 : clr);
      SEG_ADR: n_bit = n_line[n_idx[AI_W-1:0]];
      SEG_PIX: n_bit = pix_i[n_idx];
      default: n_bit = 1'b0;
    endcase
  end

  assign fetch_o      = adv_i && !last_o && (n_seg == SEG_ADR) && (seg != SEG_ADR);
  assign fetch_line_o = n_line;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg   <= SEG_HDR;
      idx   <= '0;
      line  <= '0;
      left  <= '0;
      wr    <= 1'b0;
      m1    <= 1'b0;
      clr   <= 1'b0;
      sdo_o <= 1'b0;
    end else if (start_i) begin
      seg   <= SEG_HDR;
      idx   <= '0;
      line  <= line_i;
      left  <= (count_i == '0) ? ADDR_W'(1) : count_i;
      wr    <= (cmd_i == CMD_WRITE);
      m1    <= vcom_i;
      clr   <= (cmd_i == CMD_CLEAR);
      sdo_o <= (cmd_i == CMD_WRITE);
    end else if (adv_i) begin
      if (last_o) begin
        sdo_o <= 1'b0;
      end else begin
        seg   <= n_seg;
        idx   <= n_idx;
        line  <= n_line;
        left  <= n_left;
        sdo_o <= n_bit;
      end
    end
  end
endmodule

// File: rtl/mdisp_line_writer.sv
module mdisp_line_writer
  import mdisp_pkg::*;
#(
  parameter int PIX_W        = 96,
  parameter int ADDR_W       = 7,
  parameter int LINES        = 96,
  parameter int SYS_CLK_NS   = 4,
  parameter int SCLK_HALF_NS = 500,
  parameter int CS_SETUP_NS  = 6000,
  parameter int CS_HOLD_NS   = 2000,
  parameter int CS_GAP_NS    = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [1:0]        cmd_i,
  input  logic              vcom_i,
  input  logic [ADDR_W-1:0] line_i,
  input  logic [ADDR_W-1:0] count_i,
  output logic              busy_o,
  output logic              lb_rd_en_o,
  output logic [ADDR_W-1:0] lb_rd_line_o,
  input  logic [PIX_W-1:0]  lb_rd_data_i,
  output logic              disp_cs_o,
  output logic              disp_sclk_o,
  output logic              disp_sdo_o
);
  localparam int HALF_C  = cyc_of(SCLK_HALF_NS, SYS_CLK_NS);
  localparam int SETUP_C = cyc_of(CS_SETUP_NS, SYS_CLK_NS);
  localparam int HOLD_C  = cyc_of(CS_HOLD_NS, SYS_CLK_NS);
  localparam int GAP_C   = cyc_of(CS_GAP_NS, SYS_CLK_NS);
  localparam int MAX_A   = (HALF_C > SETUP_C) ? HALF_C : SETUP_C;
  localparam int MAX_B   = (HOLD_C > GAP_C) ? HOLD_C : GAP_C;
  localparam int TW      = $clog2(((MAX_A > MAX_B) ? MAX_A : MAX_B) + 1);

  phase_t            state, nxt;
  logic              load, zero, adv, start, last, fetch;
  logic [TW-1:0]     load_val;
  logic [ADDR_W-1:0] fetch_line;
  logic [PIX_W-1:0]  pix;

  assign start = (state == PH_IDLE) && req_i;

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    adv      = 1'b0;
    case (state)
      PH_IDLE:  if (req_i) begin nxt = PH_SETUP; load = 1'b1; load_val = TW'(SETUP_C - 1); end
      PH_SETUP: if (zero) begin nxt = PH_HIGH; load = 1'b1; load_val = TW'(HALF_C - 1); end
      PH_HIGH:  if (zero) begin
        adv  = 1'b1;
        load = 1'b1;
        if (last) begin nxt = PH_HOLD; load_val = TW'(HOLD_C - 1); end
        else      begin nxt = PH_LOW;  load_val = TW'(HALF_C - 1); end
      end
      PH_LOW:   if (zero) begin nxt = PH_HIGH; load = 1'b1; load_val = TW'(HALF_C - 1); end
      PH_HOLD:  if (zero) begin nxt = PH_GAP; load = 1'b1; load_val = TW'(GAP_C - 1); end
      default:  if (zero) nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= PH_IDLE;
      busy_o      <= 1'b0;
      disp_cs_o   <= 1'b0;
      disp_sclk_o <= 1'b0;
    end else begin
      state       <= nxt;
      busy_o      <= (nxt != PH_IDLE);
      disp_cs_o   <= (nxt == PH_SETUP) || (nxt == PH_HIGH) ||
                     (nxt == PH_LOW)   || (nxt == PH_HOLD);
      disp_sclk_o <= (nxt == PH_HIGH);
    end
  end

  mdisp_phase_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .zero_o(zero)
  );

  mdisp_bit_seq #(.PIX_W(PIX_W), .ADDR_W(ADDR_W), .LINES(LINES)) u_seq (
    .clk(clk), .rst(rst), .start_i(start), .adv_i(adv), .cmd_i(cmd_i),
    .vcom_i(vcom_i), .line_i(line_i), .count_i(count_i), .pix_i(pix),
    .sdo_o(disp_sdo_o), .last_o(last), .fetch_o(fetch), .fetch_line_o(fetch_line)
  );

  mdisp_line_fetch #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst(rst), .req_i(fetch), .line_i(fetch_line),
    .rd_en_o(lb_rd_en_o), .rd_line_o(lb_rd_line_o),
    .rd_data_i(lb_rd_data_i), .pix_o(pix)
  );

  assert_sclk_inside_cs_R7: assert property (@(posedge clk) disable iff (rst)
    disp_sclk_o |-> disp_cs_o);
  assert_cs_implies_busy_R8: assert property (@(posedge clk) disable iff (rst)
    disp_cs_o |-> busy_o);
  assert_sdo_steady_high_R6: assert property (@(posedge clk) disable iff (rst)
    (disp_sclk_o && $past(disp_sclk_o)) |-> $stable(disp_sdo_o));
  assert_sdo_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !disp_cs_o |-> !disp_sdo_o);
  assert_rd_only_busy_R1: assert property (@(posedge clk) disable iff (rst)
    lb_rd_en_o |-> busy_o);
endmodule

// File: tb/mdisp_line_writer_bench.sv
module mdisp_line_writer_bench;
  localparam int H = 2, S = 5, P = 3, G = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1, req = 1'b0, vcom = 1'b0;
  logic [1:0]  cmd = 2'd0;
  logic [6:0]  line = 7'd1, cnt = 7'd1;
  logic        busy, rd_en, cs, sclk, sdo;
  logic [6:0]  rd_line;
  logic [95:0] rd_data = '0;

  int checks = 0, failures = 0;

  mdisp_line_writer #(
    .SYS_CLK_NS(4), .SCLK_HALF_NS(8), .CS_SETUP_NS(20),
    .CS_HOLD_NS(12), .CS_GAP_NS(16)
  ) u_mdisp_line_writer (
    .clk(clk), .rst(rst), .req_i(req), .cmd_i(cmd), .vcom_i(vcom),
    .line_i(line), .count_i(cnt), .busy_o(busy), .lb_rd_en_o(rd_en),
    .lb_rd_line_o(rd_line), .lb_rd_data_i(rd_data), .disp_cs_o(cs),
    .disp_sclk_o(sclk), .disp_sdo_o(sdo)
  );

  function automatic logic [95:0] pix_of(input int ln);
    logic [95:0] v;
    for (int i = 0; i < 96; i++) v[i] = (((ln * 13 + i * 5) % 7) < 3);
    return v;
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= pix_of(int'(rd_line));

  // expected bit stream
  bit    q_bit[$];
  string q_tag[$];
  int    q_ad[$];
  // expected per-cycle pins
  bit    e_cs[$], e_sclk[$], e_sdo[$], e_busy[$], e_rd[$];
  int    e_rl[$];
  string e_tag[$];

  task automatic pb(input bit b, input string t, input int ad);
    q_bit.push_back(b); q_tag.push_back(t); q_ad.push_back(ad);
  endtask

  task automatic pc(input bit c, input bit k, input bit d, input bit bz,
                    input bit r, input int rl, input string t);
    e_cs.push_back(c); e_sclk.push_back(k); e_sdo.push_back(d);
    e_busy.push_back(bz); e_rd.push_back(r); e_rl.push_back(rl); e_tag.push_back(t);
  endtask

  task automatic build(input int c, input bit v, input int st, input int n);
    int ln, nl;
    logic [95:0] px;
    q_bit.delete(); q_tag.delete(); q_ad.delete();
    e_cs.delete(); e_sclk.delete(); e_sdo.delete(); e_busy.delete();
    e_rd.delete(); e_rl.delete(); e_tag.delete();
    pb(c == 0, "R2", 0); pb(v, "R2", 0); pb(c == 2, "R2", 0);
    if (c == 0) begin
      for (int i = 0; i < 5; i++) pb(0, "R3", 0);
      nl = (n == 0) ? 1 : n;
      ln = st;
      for (int k = 0; k < nl; k++) begin
        for (int j = 0; j < 7; j++) pb(((ln >> j) & 1) != 0, "R3", (j == 0) ? ln : 0);
        pb(0, "R3", 0);
        px = pix_of(ln);
        for (int i = 0; i < 96; i++) pb(px[i], "R3", 0);
        if (k < nl - 1) for (int i = 0; i < 8; i++) pb(0, "R4", 0);
        ln = (ln == 96) ? 1 : ln + 1;
      end
      for (int i = 0; i < 16; i++) pb(0, "R4", 0);
    end else begin
      for (int i = 0; i < 13; i++) pb(0, "R5", 0);
    end
    for (int t = 0; t < S; t++) pc(1, 0, q_bit[0], 1, 0, 0, "R7");
    for (int i = 0; i < q_bit.size(); i++) begin
      for (int h = 0; h < H; h++) pc(1, 1, q_bit[i], 1, 0, 0, q_tag[i]);
      if (i < q_bit.size() - 1) begin
        for (int h = 0; h < H; h++)
          pc(1, 0, q_bit[i+1], 1, (h == 0) && (q_ad[i+1] > 0), q_ad[i+1], q_tag[i+1]);
      end
    end
    for (int t = 0; t < P; t++) pc(1, 0, 0, 1, 0, 0, "R7");
    for (int t = 0; t < G; t++) pc(0, 0, 0, 1, 0, 0, "R7");
    for (int t = 0; t < 3; t++) pc(0, 0, 0, 0, 0, 0, "R8");
  endtask

  task automatic cmp(input int t);
    bit ok_rd;
    string rq;
    checks++;
    ok_rd = (rd_en == e_rd[t]) && (!e_rd[t] || (int'(rd_line) == e_rl[t]));
    if (cs !== e_cs[t] || sclk !== e_sclk[t] || sdo !== e_sdo[t] ||
        busy !== e_busy[t] || !ok_rd) begin
      failures++;
      rq = e_tag[t];
      if (!ok_rd) rq = "R9";
      else if (sclk !== e_sclk[t]) rq = "R6";
      else if ((cs !== e_cs[t] || busy !== e_busy[t]) && rq != "R8") rq = "R7";
      $display("FAIL %s cycle %0d: got cs/sclk/sdo/busy/rd=%b%b%b%b%b line %0d, expected %b%b%b%b%b line %0d",
               rq, t, cs, sclk, sdo, busy, rd_en, rd_line,
               e_cs[t], e_sclk[t], e_sdo[t], e_busy[t], e_rd[t], e_rl[t]);
    end
  endtask

  task automatic run(input int c, input bit v, input int st, input int n, input int inj);
    build(c, v, st, n);
    @(negedge clk);
    req = 1'b1; cmd = 2'(c); vcom = v; line = 7'(st); cnt = 7'(n);
    @(negedge clk);
    req = 1'b0;
    for (int t = 0; t < e_cs.size(); t++) begin
      if (t > 0) @(negedge clk);
      if (inj >= 0 && t == inj) begin       // R8: request while busy
        req = 1'b1; cmd = 2'd2; vcom = ~v; line = 7'd3; cnt = 7'd2;
      end
      if (inj >= 0 && t == inj + 1) req = 1'b0;
      cmp(t);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog expired, busy never settled");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;                                             // R1 reset state
    if (cs || sclk || sdo || busy || rd_en) begin
      failures++;
      $display("FAIL R1 after reset got cs/sclk/sdo/busy/rd=%b%b%b%b%b expected 00000",
               cs, sclk, sdo, busy, rd_en);
    end
    run(0, 0, 1, 1, -1);      // R3 single line, first line
    run(0, 1, 96, 1, -1);     // R2 M1 high, R3 last line address
    run(0, 0, 95, 3, -1);     // R4 wrap 96 -> 1, separators and tail
    run(0, 1, 40, 0, -1);     // R4 count 0 as one line
    run(1, 1, 7, 4, -1);      // R5 hold frame
    run(2, 0, 7, 4, -1);      // R5 clear frame
    run(3, 1, 7, 4, -1);      // R2 code 3 sent as hold
    run(0, 0, 10, 2, 60);     // R8 request during busy ignored
    run(2, 1, 1, 1, 20);      // R8 during control frame
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule